// File: doc/BRIEF.md
# Host-Clocked Serial Stream Port

This block moves data between an external host and the internal FIFOs of an audio codec engine over a slow serial link. The host supplies the bit clock. The block raises a request line when one of its FIFOs needs service. For an input stream, service is due when the FIFO has room for a full burst. For the output stream, it is due when the FIFO holds a full burst. The host then clocks the programmed number of words. The request drops after the last word of the burst.

There are three streams. Compressed bytes leave the encoder on a shared serial data pin. Compressed bytes enter the decoder on the same pin. 16-bit PCM words enter the encoder on a second, separate set of clock, data and request pins. The host clock and data are sampled in the system clock domain, and their edges are detected there. Each word is assembled or serialised with a bit counter and a word counter. On the FIFO side, each stream uses a valid/ready handshake and reports a level or a free-space count.

Two option bits apply to the output stream and two apply to both input streams. One bit of each pair selects LSB-first order. The other selects the falling clock edge instead of the rising edge.

Top module: `bsp_stream_port`

## Requirements
- R1: While reset is asserted, and with no stream enabled after it, `sb_req`, `pcm_req`, `sb_doe`, `dec_wr_valid` and `pcm_wr_valid` are all 0.
- R2: With the decoder input stream enabled and `dec_space` at least the burst length, `sb_req` rises. By default each 8-bit word is captured MSB first, one bit per rising `sb_clk` edge. The word then appears on `dec_wr_data`.
- R3: With `cfg_in_lsb` = 1, input words (byte and PCM) are captured LSB first.
- R4: With `cfg_in_fall` = 1, input bits are captured on the falling host clock edge, and rising edges are not used.
- R5: A word reaches the FIFO only after all of its bits have arrived. It stays on the write port with valid high until accepted. The request drops once the burst's word count has been transferred.
- R6: Host clock edges that arrive while the stream's request is low have no effect: no word is written, and the next burst starts on a fresh word boundary.
- R7: With the encoder output stream enabled and `enc_level` at least the burst length, `sb_req` and `sb_doe` rise and bytes are popped from the FIFO. Each bit is on `sb_dout` before the host's capture edge (rising by default, MSB first) and advances after that edge. At the end of the burst, `sb_req` and `sb_doe` fall.
- R8: For the output stream, `cfg_out_lsb` = 1 selects LSB-first order and `cfg_out_fall` = 1 selects the falling capture edge.
- R9: The PCM stream carries 16-bit words on `pcm_sclk`/`pcm_sdin` with its own request `pcm_req`. It uses the input order and edge options.
- R10: Clearing a stream's enable drops its request and discards a partly received word.
- R11: While the encoder output stream is enabled, the decoder input stream cannot request the shared pin. At most one request uses the shared pin at a time.
- R12: A burst field of 0 means one word. No request is raised while the level or space count is below the burst length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enc_out_en | input | 1 | Enable encoder byte output on shared pin |
| cfg_dec_in_en | input | 1 | Enable decoder byte input on shared pin |
| cfg_pcm_in_en | input | 1 | Enable PCM word input |
| cfg_out_lsb | input | 1 | Output stream LSB first |
| cfg_out_fall | input | 1 | Output stream captured on falling edge |
| cfg_in_lsb | input | 1 | Input streams LSB first |
| cfg_in_fall | input | 1 | Input streams captured on falling edge |
| cfg_enc_burst | input | 4 | Output burst length in bytes |
| cfg_dec_burst | input | 8 | Decoder input burst length in bytes |
| cfg_pcm_burst | input | 7 | PCM input burst length in words |
| sb_clk | input | 1 | Host bit clock, shared pin set |
| sb_din | input | 1 | Shared data pin, inbound value |
| sb_dout | output | 1 | Shared data pin, outbound value |
| sb_doe | output | 1 | Shared data pin drive enable |
| sb_req | output | 1 | Shared pin set service request |
| pcm_sclk | input | 1 | Host bit clock, PCM pin set |
| pcm_sdin | input | 1 | PCM serial data |
| pcm_req | output | 1 | PCM service request |
| enc_rd_data | input | 8 | Encoder FIFO head byte |
| enc_rd_valid | input | 1 | Encoder FIFO not empty |
| enc_rd_ready | output | 1 | Pop from encoder FIFO |
| enc_level | input | 9 | Bytes held in encoder FIFO |
| dec_wr_data | output | 8 | Byte written to decoder FIFO |
| dec_wr_valid | output | 1 | Decoder write valid |
| dec_wr_ready | input | 1 | Decoder FIFO accepts |
| dec_space | input | 9 | Free entries in decoder FIFO |
| pcm_wr_data | output | 16 | Word written to PCM FIFO |
| pcm_wr_valid | output | 1 | PCM write valid |
| pcm_wr_ready | input | 1 | PCM FIFO accepts |
| pcm_space | input | 9 | Free entries in PCM FIFO |

## Verification
Asymmetric byte and word patterns (0xA5, 0x3C, 0x81, 0x96, 0x1234, 0x8001) are sent in each order and edge mode. Any bit reversal or bit misplacement therefore shows up as a wrong value. Some patterns exercise the framing rather than the data. These include clock pulses sent while the request is low, a word cut off by a disable, and bursts of zero, one and two words. They show whether the bit and word counters restart at the right moments and whether the request drops on time. The output path is tested with a FIFO that is first one byte short of a burst and then full enough. It is also tested against the decoder stream competing for the shared pin.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  localparam int BSP_CNT_W = 8;
  typedef enum logic {LN_IDLE, LN_BURST} ln_st_t;
endpackage

// File: rtl/bsp_edge_sync.sv
module bsp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_clk,
  input  logic pin_dat,
  output logic rise,
  output logic fall,
  output logic dat
);
  logic [STAGES-1:0] ck_q;
  logic [STAGES-1:0] dt_q;
  logic              prev_q;

  // clock and data travel through equal depth so they stay aligned
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q   <= '0;
      dt_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      ck_q   <= {ck_q[STAGES-2:0], pin_clk};
      dt_q   <= {dt_q[STAGES-2:0], pin_dat};
      prev_q <= ck_q[STAGES-1];
    end
  end

  always_comb begin
    rise = ck_q[STAGES-1] & ~prev_q;
    fall = ~ck_q[STAGES-1] & prev_q;
    dat  = dt_q[STAGES-1];
  end
endmodule

// File: rtl/bsp_rx_lane.sv
module bsp_rx_lane
  import bsp_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = BSP_CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          lsb_first,
  input  logic          fall_sel,
  input  logic          rise,
  input  logic          fall,
  input  logic          bit_in,
  input  logic [CW-1:0] burst,
  input  logic [CW:0]   space,
  output logic          req,
  output logic [W-1:0]  wr_data,
  output logic          wr_valid,
  input  logic          wr_ready
);
  localparam int BW = $clog2(W);

  ln_st_t        st_q, st_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [CW-1:0] word_q, word_d;
  logic [W-1:0]  sh_q, sh_d, hold_q, hold_d;
  logic          hv_q, hv_d;
  logic          edge_hit;
  logic [CW-1:0] blen;
  logic [W-1:0]  sh_next;

  always_comb begin
    edge_hit = fall_sel ? fall : rise;
    blen     = (burst == '0) ? CW'(1) : burst;
    sh_next  = lsb_first ? {bit_in, sh_q[W-1:1]} : {sh_q[W-2:0], bit_in};
    st_d     = st_q;
    bit_d    = bit_q;
    word_d   = word_q;
    sh_d     = sh_q;
    hold_d   = hold_q;
    hv_d     = hv_q;
    if (hv_q && wr_ready) hv_d = 1'b0;
    if (!en) begin
      st_d  = LN_IDLE;
      bit_d = '0;
      word_d = '0;
    end else begin
      case (st_q)
        LN_IDLE: begin
          if (!hv_q && (space >= {1'b0, blen})) begin
            st_d   = LN_BURST;
            bit_d  = '0;
            word_d = '0;
          end
        end
        default: begin
          if (edge_hit) begin
            sh_d = sh_next;
            if (bit_q == BW'(W-1)) begin
              bit_d  = '0;
              hold_d = sh_next;
              hv_d   = 1'b1;
              if (word_q == blen - CW'(1)) st_d = LN_IDLE;
              else                         word_d = word_q + CW'(1);
            end else begin
              bit_d = bit_q + BW'(1);
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LN_IDLE;
      bit_q  <= '0;
      word_q <= '0;
      sh_q   <= '0;
      hold_q <= '0;
      hv_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      word_q <= word_d;
      sh_q   <= sh_d;
      hold_q <= hold_d;
      hv_q   <= hv_d;
    end
  end

  assign req      = (st_q == LN_BURST);
  assign wr_data  = hold_q;
  assign wr_valid = hv_q;

  // R5
  rx_hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));

  // R5
  rx_req_drop_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(req) && $past(en)) |-> wr_valid);
endmodule

// File: rtl/bsp_tx_lane.sv
module bsp_tx_lane
  import bsp_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = BSP_CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          lsb_first,
  input  logic          fall_sel,
  input  logic          rise,
  input  logic          fall,
  input  logic [CW-1:0] burst,
  input  logic [CW:0]   level,
  input  logic [W-1:0]  rd_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  output logic          req,
  output logic          dout,
  output logic          doe
);
  localparam int BW = $clog2(W);

  ln_st_t        st_q, st_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [CW-1:0] word_q, word_d;
  logic [W-1:0]  sh_q, sh_d;
  logic          ld_q, ld_d;
  logic          edge_hit;
  logic [CW-1:0] blen;

  always_comb begin
    edge_hit = fall_sel ? fall : rise;
    blen     = (burst == '0) ? CW'(1) : burst;
    rd_ready = en && (st_q == LN_BURST) && !ld_q;
    st_d     = st_q;
    bit_d    = bit_q;
    word_d   = word_q;
    sh_d     = sh_q;
    ld_d     = ld_q;
    if (!en) begin
      st_d  = LN_IDLE;
      ld_d  = 1'b0;
      bit_d = '0;
    end else begin
      case (st_q)
        LN_IDLE: begin
          if (level >= {1'b0, blen}) begin
            st_d   = LN_BURST;
            word_d = '0;
            ld_d   = 1'b0;
          end
        end
        default: begin
          if (!ld_q) begin
            if (rd_valid) begin
              sh_d  = rd_data;
              ld_d  = 1'b1;
              bit_d = '0;
            end
          end else if (edge_hit) begin
            if (bit_q == BW'(W-1)) begin
              ld_d = 1'b0;
              if (word_q == blen - CW'(1)) st_d = LN_IDLE;
              else                         word_d = word_q + CW'(1);
            end else begin
              sh_d  = lsb_first ? (sh_q >> 1) : (sh_q << 1);
              bit_d = bit_q + BW'(1);
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LN_IDLE;
      bit_q  <= '0;
      word_q <= '0;
      sh_q   <= '0;
      ld_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      word_q <= word_d;
      sh_q   <= sh_d;
      ld_q   <= ld_d;
    end
  end

  assign req  = (st_q == LN_BURST);
  assign doe  = (st_q == LN_BURST);
  assign dout = ((st_q == LN_BURST) && ld_q) ? (lsb_first ? sh_q[0] : sh_q[W-1]) : 1'b0;

  // R7
  tx_bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q == LN_BURST) && $stable(lsb_first) && !$stable(dout))
      |-> $past(edge_hit || (rd_ready && rd_valid) || !en));
endmodule

// File: rtl/bsp_stream_port.sv
module bsp_stream_port
  import bsp_pkg::*;
#(
  parameter int CNT_W       = BSP_CNT_W,
  parameter int BYTE_W      = 8,
  parameter int PCM_W       = 16,
  parameter int ENC_BURST_W = 4,
  parameter int DEC_BURST_W = 8,
  parameter int PCM_BURST_W = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_enc_out_en,
  input  logic                   cfg_dec_in_en,
  input  logic                   cfg_pcm_in_en,
  input  logic                   cfg_out_lsb,
  input  logic                   cfg_out_fall,
  input  logic                   cfg_in_lsb,
  input  logic                   cfg_in_fall,
  input  logic [ENC_BURST_W-1:0] cfg_enc_burst,
  input  logic [DEC_BURST_W-1:0] cfg_dec_burst,
  input  logic [PCM_BURST_W-1:0] cfg_pcm_burst,
  input  logic                   sb_clk,
  input  logic                   sb_din,
  output logic                   sb_dout,
  output logic                   sb_doe,
  output logic                   sb_req,
  input  logic                   pcm_sclk,
  input  logic                   pcm_sdin,
  output logic                   pcm_req,
  input  logic [BYTE_W-1:0]      enc_rd_data,
  input  logic                   enc_rd_valid,
  output logic                   enc_rd_ready,
  input  logic [CNT_W:0]         enc_level,
  output logic [BYTE_W-1:0]      dec_wr_data,
  output logic                   dec_wr_valid,
  input  logic                   dec_wr_ready,
  input  logic [CNT_W:0]         dec_space,
  output logic [PCM_W-1:0]       pcm_wr_data,
  output logic                   pcm_wr_valid,
  input  logic                   pcm_wr_ready,
  input  logic [CNT_W:0]         pcm_space
);
  logic [1:0] rs_q;
  logic       rst_core_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  logic sb_rise, sb_fall, sb_dat;
  logic pc_rise, pc_fall, pc_dat;
  logic tx_req, rxb_req;
  logic dec_lane_en;

  assign dec_lane_en = cfg_dec_in_en && !cfg_enc_out_en;

  bsp_edge_sync #(.STAGES(SYNC_STAGES)) u_sb_sync (
    .clk(clk), .rst_n(rst_core_n), .pin_clk(sb_clk), .pin_dat(sb_din),
    .rise(sb_rise), .fall(sb_fall), .dat(sb_dat));

  bsp_edge_sync #(.STAGES(SYNC_STAGES)) u_pcm_sync (
    .clk(clk), .rst_n(rst_core_n), .pin_clk(pcm_sclk), .pin_dat(pcm_sdin),
    .rise(pc_rise), .fall(pc_fall), .dat(pc_dat));

  bsp_tx_lane #(.W(BYTE_W), .CW(CNT_W)) u_enc_tx (
    .clk(clk), .rst_n(rst_core_n), .en(cfg_enc_out_en),
    .lsb_first(cfg_out_lsb), .fall_sel(cfg_out_fall),
    .rise(sb_rise), .fall(sb_fall), .burst(CNT_W'(cfg_enc_burst)),
    .level(enc_level), .rd_data(enc_rd_data), .rd_valid(enc_rd_valid),
    .rd_ready(enc_rd_ready), .req(tx_req), .dout(sb_dout), .doe(sb_doe));

  bsp_rx_lane #(.W(BYTE_W), .CW(CNT_W)) u_dec_rx (
    .clk(clk), .rst_n(rst_core_n), .en(dec_lane_en),
    .lsb_first(cfg_in_lsb), .fall_sel(cfg_in_fall),
    .rise(sb_rise), .fall(sb_fall), .bit_in(sb_dat),
    .burst(CNT_W'(cfg_dec_burst)), .space(dec_space), .req(rxb_req),
    .wr_data(dec_wr_data), .wr_valid(dec_wr_valid), .wr_ready(dec_wr_ready));

  bsp_rx_lane #(.W(PCM_W), .CW(CNT_W)) u_pcm_rx (
    .clk(clk), .rst_n(rst_core_n), .en(cfg_pcm_in_en),
    .lsb_first(cfg_in_lsb), .fall_sel(cfg_in_fall),
    .rise(pc_rise), .fall(pc_fall), .bit_in(pc_dat),
    .burst(CNT_W'(cfg_pcm_burst)), .space(pcm_space), .req(pcm_req),
    .wr_data(pcm_wr_data), .wr_valid(pcm_wr_valid), .wr_ready(pcm_wr_ready));

  assign sb_req = tx_req | rxb_req;

  // R11
  shared_pin_excl_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0({tx_req, rxb_req}));

  // R11
  enc_priority_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $past(cfg_enc_out_en) |-> !rxb_req);
endmodule

// File: tb/tb_bsp_stream_port.sv
module tb_bsp_stream_port;
  localparam int H = 4;

  logic clk;
  logic rst_n;
  logic cfg_enc_out_en, cfg_dec_in_en, cfg_pcm_in_en;
  logic cfg_out_lsb, cfg_out_fall, cfg_in_lsb, cfg_in_fall;
  logic [3:0] cfg_enc_burst;
  logic [7:0] cfg_dec_burst;
  logic [6:0] cfg_pcm_burst;
  logic sb_clk, sb_din, sb_dout, sb_doe, sb_req;
  logic pcm_sclk, pcm_sdin, pcm_req;
  logic [7:0] enc_rd_data;
  logic enc_rd_valid, enc_rd_ready;
  logic [8:0] enc_level;
  logic [7:0] dec_wr_data;
  logic dec_wr_valid, dec_wr_ready;
  logic [8:0] dec_space;
  logic [15:0] pcm_wr_data;
  logic pcm_wr_valid, pcm_wr_ready;
  logic [8:0] pcm_space;

  int checks = 0;
  int bad = 0;
  int dec_cnt = 0;
  int pcm_cnt = 0;
  bit finished = 0;

  logic [15:0] exp_dec[$];
  string       tag_dec[$];
  logic [15:0] exp_pcm[$];
  string       tag_pcm[$];
  logic [7:0]  tx_q[$];
  logic [7:0]  exp_tx[$];
  logic        tx_pend;
  logic [7:0]  tx_dummy;

  bsp_stream_port dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_enc_out_en(cfg_enc_out_en), .cfg_dec_in_en(cfg_dec_in_en), .cfg_pcm_in_en(cfg_pcm_in_en),
    .cfg_out_lsb(cfg_out_lsb), .cfg_out_fall(cfg_out_fall),
    .cfg_in_lsb(cfg_in_lsb), .cfg_in_fall(cfg_in_fall),
    .cfg_enc_burst(cfg_enc_burst), .cfg_dec_burst(cfg_dec_burst), .cfg_pcm_burst(cfg_pcm_burst),
    .sb_clk(sb_clk), .sb_din(sb_din), .sb_dout(sb_dout), .sb_doe(sb_doe), .sb_req(sb_req),
    .pcm_sclk(pcm_sclk), .pcm_sdin(pcm_sdin), .pcm_req(pcm_req),
    .enc_rd_data(enc_rd_data), .enc_rd_valid(enc_rd_valid), .enc_rd_ready(enc_rd_ready),
    .enc_level(enc_level),
    .dec_wr_data(dec_wr_data), .dec_wr_valid(dec_wr_valid), .dec_wr_ready(dec_wr_ready),
    .dec_space(dec_space),
    .pcm_wr_data(pcm_wr_data), .pcm_wr_valid(pcm_wr_valid), .pcm_wr_ready(pcm_wr_ready),
    .pcm_space(pcm_space));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic ser_bits(input bit pcm, input logic [15:0] w, input int width,
                          input int nbits, input bit lsb);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = lsb ? w[i] : w[width-1-i];
      if (pcm) pcm_sdin = b; else sb_din = b;
      tick(H);
      if (pcm) pcm_sclk = 1'b1; else sb_clk = 1'b1;
      tick(H);
      if (pcm) pcm_sclk = 1'b0; else sb_clk = 1'b0;
      tick(H);
    end
  endtask

  task automatic send_dec(input logic [7:0] v, input string tag);
    exp_dec.push_back({8'h00, v});
    tag_dec.push_back(tag);
    ser_bits(1'b0, {8'h00, v}, 8, 8, cfg_in_lsb);
  endtask

  task automatic send_pcm(input logic [15:0] v, input string tag);
    exp_pcm.push_back(v);
    tag_pcm.push_back(tag);
    ser_bits(1'b1, v, 16, 16, cfg_in_lsb);
  endtask

  task automatic recv_byte(input string tag);
    logic [7:0] v;
    logic [7:0] e;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      logic b;
      tick(H);
      if (!cfg_out_fall) begin
        b = sb_dout; sb_clk = 1'b1; tick(H); sb_clk = 1'b0;
      end else begin
        sb_clk = 1'b1; tick(H); b = sb_dout; sb_clk = 1'b0;
      end
      tick(H);
      if (cfg_out_lsb) v[i] = b; else v[7-i] = b;
    end
    e = (exp_tx.size() > 0) ? exp_tx.pop_front() : 8'hxx;
    chk(tag, {24'h0, v}, {24'h0, e});
  endtask

  // encoder FIFO model: handshake seen mid-cycle, pop applied one cycle later
  always @(negedge clk) begin
    if (tx_pend === 1'b1) tx_dummy = tx_q.pop_front();
    enc_rd_valid = (tx_q.size() > 0);
    enc_rd_data  = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
    enc_level    = 9'(tx_q.size());
    tx_pend      = enc_rd_ready && enc_rd_valid;
  end

  // monitor: pops expected words as the FIFO writes appear
  always @(negedge clk) begin
    if (rst_n && dec_wr_valid === 1'b1) begin
      dec_cnt++;
      if (exp_dec.size() == 0) chk("R6 unexpected decoder byte", {24'h0, dec_wr_data}, 32'hffff_ffff);
      else chk(tag_dec.pop_front(), {24'h0, dec_wr_data}, {16'h0, exp_dec.pop_front()});
    end
    if (rst_n && pcm_wr_valid === 1'b1) begin
      pcm_cnt++;
      if (exp_pcm.size() == 0) chk("R9 unexpected PCM word", {16'h0, pcm_wr_data}, 32'hffff_ffff);
      else chk(tag_pcm.pop_front(), {16'h0, pcm_wr_data}, {16'h0, exp_pcm.pop_front()});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int c0;
    rst_n = 1'b0;
    cfg_enc_out_en = 0; cfg_dec_in_en = 0; cfg_pcm_in_en = 0;
    cfg_out_lsb = 0; cfg_out_fall = 0; cfg_in_lsb = 0; cfg_in_fall = 0;
    cfg_enc_burst = 4'd8; cfg_dec_burst = 8'd32; cfg_pcm_burst = 7'd32;
    sb_clk = 0; sb_din = 0; pcm_sclk = 0; pcm_sdin = 0;
    dec_wr_ready = 1; pcm_wr_ready = 1;
    dec_space = 0; pcm_space = 0;
    tx_pend = 0;
    tick(6);
    chk("R1 reset sb_req", {31'h0, sb_req}, 0);
    chk("R1 reset pcm_req", {31'h0, pcm_req}, 0);
    chk("R1 reset sb_doe", {31'h0, sb_doe}, 0);
    chk("R1 reset write valids", {30'h0, dec_wr_valid, pcm_wr_valid}, 0);
    rst_n = 1'b1;
    tick(6);
    chk("R1 idle after reset", {30'h0, sb_req, pcm_req}, 0);

    // R2: default MSB first, rising edge, burst of two
    cfg_dec_in_en = 1; cfg_dec_burst = 2; dec_space = 100;
    tick(4);
    chk("R2 request raised", {31'h0, sb_req}, 1);
    dec_space = 0;
    c0 = dec_cnt;
    send_dec(8'hA5, "R2 msb rising word0");
    send_dec(8'h3C, "R2 msb rising word1");
    tick(10);
    chk("R5 request dropped after burst", {31'h0, sb_req}, 0);
    chk("R2 two words written", dec_cnt - c0, 2);

    // R5: nothing written before the last bit
    cfg_dec_burst = 1; dec_space = 100;
    tick(4);
    dec_space = 0;
    c0 = dec_cnt;
    ser_bits(1'b0, 16'h00D2, 8, 7, 1'b0);
    tick(6);
    chk("R5 no commit after 7 bits", dec_cnt - c0, 0);
    exp_dec.push_back(16'h00D2); tag_dec.push_back("R5 word after last bit");
    sb_din = 1'b0; tick(H); sb_clk = 1; tick(H); sb_clk = 0; tick(H);
    tick(6);
    chk("R5 commit after 8th bit", dec_cnt - c0, 1);

    // R3: LSB first
    cfg_in_lsb = 1; cfg_dec_burst = 2; dec_space = 100;
    tick(4); dec_space = 0;
    send_dec(8'h81, "R3 lsb word0");
    send_dec(8'h0F, "R3 lsb word1");
    tick(10);

    // R4: falling edge capture
    cfg_in_lsb = 0; cfg_in_fall = 1; dec_space = 100;
    tick(4); dec_space = 0;
    send_dec(8'h96, "R4 falling word0");
    send_dec(8'h5A, "R4 falling word1");
    tick(10);
    cfg_in_fall = 0;

    // R12: space below burst; R6: edges with request low
    cfg_dec_burst = 4; dec_space = 3;
    tick(6);
    chk("R12 no request with space below burst", {31'h0, sb_req}, 0);
    c0 = dec_cnt;
    ser_bits(1'b0, 16'h00FF, 8, 8, 1'b0);
    tick(6);
    chk("R6 edges while idle write nothing", dec_cnt - c0, 0);
    cfg_dec_burst = 1; dec_space = 100;
    tick(4); dec_space = 0;
    send_dec(8'h42, "R6 next burst aligned");
    tick(8);

    // R12: burst field zero means one word
    cfg_dec_burst = 0; dec_space = 100;
    tick(4);
    chk("R12 request with burst zero", {31'h0, sb_req}, 1);
    dec_space = 0;
    send_dec(8'h77, "R12 single word burst");
    tick(8);
    chk("R12 request low after one word", {31'h0, sb_req}, 0);

    // R10: disable mid-word
    cfg_dec_burst = 1; dec_space = 100;
    tick(4);
    c0 = dec_cnt;
    ser_bits(1'b0, 16'h00B0, 8, 5, 1'b0);
    cfg_dec_in_en = 0;
    tick(4);
    chk("R10 request dropped on disable", {31'h0, sb_req}, 0);
    chk("R10 partial word discarded", dec_cnt - c0, 0);
    cfg_dec_in_en = 1;
    tick(4); dec_space = 0;
    send_dec(8'hC3, "R10 fresh word after re-enable");
    tick(8);
    cfg_dec_in_en = 0;

    // R9: PCM stream
    cfg_pcm_in_en = 1; cfg_pcm_burst = 2; pcm_space = 100;
    tick(4);
    chk("R9 PCM request", {31'h0, pcm_req}, 1);
    chk("R9 shared request untouched", {31'h0, sb_req}, 0);
    pcm_space = 0;
    send_pcm(16'h1234, "R9 pcm word0");
    send_pcm(16'hBEEF, "R9 pcm word1");
    tick(10);
    chk("R9 PCM request dropped", {31'h0, pcm_req}, 0);
    cfg_in_lsb = 1; cfg_in_fall = 1; cfg_pcm_burst = 1; pcm_space = 100;
    tick(4); pcm_space = 0;
    send_pcm(16'h8001, "R3 R4 pcm lsb falling");
    tick(10);
    cfg_in_lsb = 0; cfg_in_fall = 0; cfg_pcm_in_en = 0;

    // R7: encoder output
    cfg_enc_burst = 2; cfg_enc_out_en = 1;
    tx_q.push_back(8'hA5); exp_tx.push_back(8'hA5);
    tick(6);
    chk("R12 no output request below burst", {31'h0, sb_req}, 0);
    tx_q.push_back(8'h3C); exp_tx.push_back(8'h3C);
    tick(6);
    chk("R7 output request and drive", {30'h0, sb_req, sb_doe}, 3);
    recv_byte("R7 msb rising byte0");
    recv_byte("R7 msb rising byte1");
    tick(8);
    chk("R7 request and drive off after burst", {30'h0, sb_req, sb_doe}, 0);

    // R8: LSB first, falling edge
    cfg_out_lsb = 1; cfg_out_fall = 1;
    tx_q.push_back(8'hC1); exp_tx.push_back(8'hC1);
    tx_q.push_back(8'h2E); exp_tx.push_back(8'h2E);
    tick(6);
    recv_byte("R8 lsb falling byte0");
    recv_byte("R8 lsb falling byte1");
    tick(8);
    cfg_out_lsb = 0; cfg_out_fall = 0;

    // R11: encoder output blocks decoder input
    cfg_dec_in_en = 1; cfg_dec_burst = 1; dec_space = 100;
    tick(8);
    chk("R11 decoder blocked by encoder enable", {31'h0, sb_req}, 0);
    cfg_enc_out_en = 0;
    tick(6);
    chk("R11 decoder requests once released", {31'h0, sb_req}, 1);
    cfg_dec_in_en = 0; dec_space = 0;
    tick(20);

    chk("R2 all expected words delivered", exp_dec.size() + exp_pcm.size() + exp_tx.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule